// File: doc/BRIEF.md
# Egress Packet FIFO with Drop Control

This block buffers packet words on their way out of a chip, with one small FIFO for each egress port. Words arrive on a single write interface that carries a port address and start-of-packet, end-of-packet and error flags. A global mode input chooses how the FIFOs behave. In store-and-forward mode a packet is held back until it has been written completely and cleanly. A malformed or overflowing packet is removed by moving the write pointer back to where the packet began, and each removal adds one to that port's saturating drop counter. In streaming mode every accepted word can be read on the next cycle.

Each port also keeps three sticky status bits: FIFO full, write to a disabled port, and data without a start-of-packet. A register read port returns any status vector, or one port's drop counter, and clears what it has read. An interrupt output is raised when a status bit is set and its mask bit is 0. A simple pop interface takes words out of any port.

Top module: `egress_pkt_fifo`

## Requirements
- R1: With `cfg_stream_mode`=0 (store-and-forward), `pkt_avail[i]` stays 0 while a packet is being written and goes to 1 in the cycle after its end-of-packet word is accepted without a drop.
- R2: In store-and-forward mode, a word carrying both start-of-packet and end-of-packet is discarded, and the port's drop counter goes up by one.
- R3: In store-and-forward mode, `wr_err` on any word of an open packet drops the whole packet and counts it once. The remaining words up to and including end-of-packet are discarded and set no status bit.
- R4: In store-and-forward mode, a word that arrives while the port holds DEPTH words drops the packet and counts it. The write pointer returns to the packet's first word, so later packets are stored normally.
- R5: With `cfg_stream_mode`=1, each accepted word is readable in the next cycle. The conditions of R2 to R4 discard no packet and leave the drop counter unchanged.
- R6: A word written to a port whose `cfg_port_en` bit is 0 is discarded, and bit i of the disabled-error status is set.
- R7: A word without start-of-packet that arrives at a port with no packet open is discarded and sets that port's start-of-packet error bit.
- R8: A port's full status bit is set when the port holds DEPTH words.
- R9: The status vectors are selected by `reg_sel` code 0 (full), 1 (disabled error) or 2 (start-of-packet error), with bit i belonging to port i. `reg_rdata` returns the vector on the cycle after `reg_rd`, and the vector is cleared in the same cycle.
- R10: `irq` is a registered OR of all status bits whose mask bit (`cfg_full_mask`, `cfg_dis_mask`, `cfg_soperr_mask`) is 0. A mask bit of 1 keeps its status bit from raising `irq`.
- R11: `reg_sel` code 3 returns the drop counter of port `reg_port` and clears it. The counter stops at its maximum value and does not wrap.
- R12: A counter read and a drop on the same port in the same cycle return the old value and leave the counter at 1.
- R13: `rd_en` with `rd_port` pops the oldest readable word of that port. `rd_valid`, `rd_data`, `rd_sop` and `rd_eop` show it on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_stream_mode | input | 1 | 0 store-and-forward, 1 streaming |
| cfg_port_en | input | NUM_PORTS | per-port enable |
| cfg_full_mask | input | NUM_PORTS | full interrupt mask, 1 suppresses |
| cfg_dis_mask | input | NUM_PORTS | disabled-error interrupt mask, 1 suppresses |
| cfg_soperr_mask | input | NUM_PORTS | start-of-packet error interrupt mask, 1 suppresses |
| wr_en | input | 1 | write strobe |
| wr_port | input | PORT_W | destination port |
| wr_data | input | DATA_W | packet word |
| wr_sop | input | 1 | start of packet |
| wr_eop | input | 1 | end of packet |
| wr_err | input | 1 | packet error |
| rd_en | input | 1 | pop request |
| rd_port | input | PORT_W | port to pop |
| rd_valid | output | 1 | popped word valid |
| rd_data | output | DATA_W | popped word |
| rd_sop | output | 1 | popped word starts a packet |
| rd_eop | output | 1 | popped word ends a packet |
| pkt_avail | output | NUM_PORTS | port has a readable word |
| reg_rd | input | 1 | register read strobe |
| reg_sel | input | 2 | register select |
| reg_port | input | PORT_W | port for counter read |
| reg_rdata | output | REG_W | register read data |
| irq | output | 1 | interrupt |

## Verification
The assertions check on every cycle that no port ever holds more than DEPTH words and that readable data never runs ahead of the write pointer. They also check that streaming mode never drops, that a write to a disabled port leaves its pointer unchanged, that the counter saturates and reads back as 1 after a read in the same cycle as a drop, and that `irq` stays low when every mask bit is set. Only the bench scenarios can show that each drop condition removes exactly one packet and that the FIFO takes later packets after a rollback. The same holds for the words read back, for clear-on-read of each register, and for the exact cycles at which `pkt_avail` and `irq` change.

// File: rtl/efifo_pkg.sv
package efifo_pkg;
  typedef enum logic [1:0] {
    SEL_FULL   = 2'd0,
    SEL_DIS    = 2'd1,
    SEL_SOPERR = 2'd2,
    SEL_DROPS  = 2'd3
  } efifo_sel_e;
endpackage

// File: rtl/efifo_ram.sv
module efifo_ram #(
  parameter int W  = 34,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int N = 1 << AW;
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/efifo_sat_cnt.sv
module efifo_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (clr)               cnt <= inc ? W'(1) : '0;
    else if (inc && cnt != MAX) cnt <= cnt + W'(1);
  end

  // R11
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == MAX) |=> cnt == MAX);
  // R12
  cnt_clr_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && inc) |=> cnt == W'(1));
endmodule

// File: rtl/efifo_port_ctl.sv
module efifo_port_ctl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stream,
  input  logic          port_en,
  input  logic          we,
  input  logic          sop,
  input  logic          eop,
  input  logic          err,
  input  logic          pop,
  input  logic          clr_full,
  input  logic          clr_dis,
  input  logic          clr_soperr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW-1:0] mem_raddr,
  output logic          avail,
  output logic          drop_inc,
  output logic          st_full,
  output logic          st_dis,
  output logic          st_soperr
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr, commit, rptr, nxt_w, nxt_c, wr_at;
  logic in_pkt, skip, nxt_in, nxt_skip;
  logic full, base_full, set_dis, set_soperr;

  assign full      = (wptr - rptr) == PW'(DEPTH);
  assign base_full = (commit - rptr) == PW'(DEPTH);
  assign avail     = commit != rptr;
  assign mem_waddr = wr_at[AW-1:0];
  assign mem_raddr = rptr[AW-1:0];

  always_comb begin
    nxt_w = wptr; nxt_c = commit; nxt_in = in_pkt; nxt_skip = skip;
    wr_at = wptr; mem_we = 1'b0; drop_inc = 1'b0;
    set_dis = 1'b0; set_soperr = 1'b0;
    if (we) begin
      if (!port_en) set_dis = 1'b1;
      else if (stream) begin
        nxt_skip = 1'b0;
        if (!sop && !in_pkt) set_soperr = 1'b1;
        else begin
          nxt_in = !eop;
          if (!full) begin
            mem_we = 1'b1; nxt_w = wptr + PW'(1); nxt_c = wptr + PW'(1);
          end
        end
      end else if (sop) begin
        nxt_w = commit; nxt_in = 1'b0; nxt_skip = 1'b0;
        if (eop) drop_inc = 1'b1;
        else if (err || base_full) begin
          drop_inc = 1'b1; nxt_skip = 1'b1;
        end else begin
          mem_we = 1'b1; wr_at = commit; nxt_w = commit + PW'(1); nxt_in = 1'b1;
        end
      end else if (skip) begin
        if (eop) nxt_skip = 1'b0;
      end else if (!in_pkt) set_soperr = 1'b1;
      else if (err || full) begin
        drop_inc = 1'b1; nxt_w = commit; nxt_in = 1'b0; nxt_skip = !eop;
      end else begin
        mem_we = 1'b1; nxt_w = wptr + PW'(1);
        if (eop) begin nxt_c = wptr + PW'(1); nxt_in = 1'b0; end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; commit <= '0; rptr <= '0; in_pkt <= 1'b0; skip <= 1'b0;
      st_full <= 1'b0; st_dis <= 1'b0; st_soperr <= 1'b0;
    end else begin
      wptr <= nxt_w; commit <= nxt_c; in_pkt <= nxt_in; skip <= nxt_skip;
      if (pop) rptr <= rptr + PW'(1);
      st_full   <= (st_full & ~clr_full) | full;
      st_dis    <= (st_dis & ~clr_dis) | set_dis;
      st_soperr <= (st_soperr & ~clr_soperr) | set_soperr;
    end
  end

  // R4
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (wptr - rptr) <= PW'(DEPTH));
  // R1
  commit_le_write_chk: assert property (@(posedge clk) disable iff (rst)
    (commit - rptr) <= (wptr - rptr));
  // R5
  stream_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    stream |-> !drop_inc);
  // R6
  dis_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !port_en) |=> $stable(wptr));
endmodule

// File: rtl/egress_pkt_fifo.sv
module egress_pkt_fifo
  import efifo_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  parameter int CNT_W     = 16,
  parameter int REG_W     = 32,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_stream_mode,
  input  logic [NUM_PORTS-1:0] cfg_port_en,
  input  logic [NUM_PORTS-1:0] cfg_full_mask,
  input  logic [NUM_PORTS-1:0] cfg_dis_mask,
  input  logic [NUM_PORTS-1:0] cfg_soperr_mask,
  input  logic                 wr_en,
  input  logic [PORT_W-1:0]    wr_port,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 wr_sop,
  input  logic                 wr_eop,
  input  logic                 wr_err,
  input  logic                 rd_en,
  input  logic [PORT_W-1:0]    rd_port,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_sop,
  output logic                 rd_eop,
  output logic [NUM_PORTS-1:0] pkt_avail,
  input  logic                 reg_rd,
  input  logic [1:0]           reg_sel,
  input  logic [PORT_W-1:0]    reg_port,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DATA_W + 2;

  efifo_sel_e sel;
  logic [NUM_PORTS-1:0] st_full, st_dis, st_soperr, pop;
  logic [EW-1:0]        ram_q [NUM_PORTS];
  logic [CNT_W-1:0]     cnt_q [NUM_PORTS];
  logic [PORT_W-1:0]    rd_sel_q;
  logic clr_full, clr_dis, clr_soperr;

  assign sel        = efifo_sel_e'(reg_sel);
  assign clr_full   = reg_rd && sel == SEL_FULL;
  assign clr_dis    = reg_rd && sel == SEL_DIS;
  assign clr_soperr = reg_rd && sel == SEL_SOPERR;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic          we_i, mwe, drop;
    logic [AW-1:0] wa, ra;

    assign we_i   = wr_en && wr_port == PORT_W'(i);
    assign pop[i] = rd_en && rd_port == PORT_W'(i) && pkt_avail[i];

    efifo_port_ctl #(.DEPTH(DEPTH), .AW(AW)) u_ctl (
      .clk(clk), .rst(rst), .stream(cfg_stream_mode), .port_en(cfg_port_en[i]),
      .we(we_i), .sop(wr_sop), .eop(wr_eop), .err(wr_err), .pop(pop[i]),
      .clr_full(clr_full), .clr_dis(clr_dis), .clr_soperr(clr_soperr),
      .mem_we(mwe), .mem_waddr(wa), .mem_raddr(ra), .avail(pkt_avail[i]),
      .drop_inc(drop), .st_full(st_full[i]), .st_dis(st_dis[i]),
      .st_soperr(st_soperr[i])
    );

    efifo_ram #(.W(EW), .AW(AW)) u_ram (
      .clk(clk), .we(mwe), .waddr(wa), .wdata({wr_sop, wr_eop, wr_data}),
      .re(pop[i]), .raddr(ra), .rdata(ram_q[i])
    );

    efifo_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(drop),
      .clr(reg_rd && sel == SEL_DROPS && reg_port == PORT_W'(i)),
      .cnt(cnt_q[i])
    );
  end

  assign {rd_sop, rd_eop, rd_data} = ram_q[rd_sel_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0; rd_sel_q <= '0; reg_rdata <= '0; irq <= 1'b0;
    end else begin
      rd_valid <= |pop;
      if (rd_en) rd_sel_q <= rd_port;
      irq <= |((st_full & ~cfg_full_mask) | (st_dis & ~cfg_dis_mask) |
               (st_soperr & ~cfg_soperr_mask));
      if (reg_rd) begin
        case (sel)
          SEL_FULL:   reg_rdata <= REG_W'(st_full);
          SEL_DIS:    reg_rdata <= REG_W'(st_dis);
          SEL_SOPERR: reg_rdata <= REG_W'(st_soperr);
          default:    reg_rdata <= REG_W'(cnt_q[reg_port]);
        endcase
      end
    end
  end

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (&{cfg_full_mask, cfg_dis_mask, cfg_soperr_mask}) |=> !irq);
  // R13
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !pkt_avail[rd_port]) |=> !rd_valid);
endmodule

// File: tb/test_egress_pkt_fifo.sv
`timescale 1ns/1ps
module test_egress_pkt_fifo;
  localparam int N = 16, DW = 32, DEPTH = 4, CW = 4, PW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic stream = 1'b0;
  logic [N-1:0] port_en = '1, m_full = '1, m_dis = '1, m_sop = '1;
  logic wr_en = 0, wr_sop = 0, wr_eop = 0, wr_err = 0;
  logic [PW-1:0] wr_port = '0, rd_port = '0, reg_port = '0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 0, reg_rd = 0;
  logic [1:0] reg_sel = '0;
  logic rd_valid, rd_sop, rd_eop, irq;
  logic [DW-1:0] rd_data;
  logic [N-1:0] pkt_avail;
  logic [31:0] reg_rdata;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  egress_pkt_fifo #(.NUM_PORTS(N), .DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) i_egress_pkt_fifo (
    .clk(clk), .rst(rst), .cfg_stream_mode(stream), .cfg_port_en(port_en),
    .cfg_full_mask(m_full), .cfg_dis_mask(m_dis), .cfg_soperr_mask(m_sop),
    .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data), .wr_sop(wr_sop),
    .wr_eop(wr_eop), .wr_err(wr_err), .rd_en(rd_en), .rd_port(rd_port),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop),
    .pkt_avail(pkt_avail), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_port(reg_port), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int p, input logic [31:0] d, input logic s, input logic e, input logic er);
    @(negedge clk);
    wr_en = 1; wr_port = PW'(p); wr_data = d; wr_sop = s; wr_eop = e; wr_err = er;
    @(negedge clk);
    wr_en = 0; wr_sop = 0; wr_eop = 0; wr_err = 0;
  endtask

  task automatic rreg(input logic [1:0] s, input int p, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1; reg_sel = s; reg_port = PW'(p);
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  task automatic pop_chk(input string tag, input int p, input logic [31:0] d, input logic s, input logic e);
    @(negedge clk);
    rd_en = 1; rd_port = PW'(p);
    @(negedge clk);
    rd_en = 0;
    check({tag, " valid"}, 32'(rd_valid), 1);
    check({tag, " data"}, rd_data, d);
    check({tag, " flags"}, {30'd0, rd_sop, rd_eop}, {30'd0, s, e});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R13 reset avail", 32'(pkt_avail), 0);
    check("R10 reset irq", 32'(irq), 0);
    rreg(2'd0, 0, v); check("R9 reset full", v, 0);
    rreg(2'd3, 0, v); check("R11 reset count", v, 0);
  endtask

  task automatic t_saf_good();
    wr(1, 32'hA0, 1, 0, 0);
    wr(1, 32'hA1, 0, 0, 0);
    check("R1 hidden before eop", 32'(pkt_avail[1]), 0);
    wr(1, 32'hA2, 0, 1, 0);
    check("R1 visible after eop", 32'(pkt_avail[1]), 1);
    pop_chk("R13 w0", 1, 32'hA0, 1, 0);
    pop_chk("R13 w1", 1, 32'hA1, 0, 0);
    pop_chk("R13 w2", 1, 32'hA2, 0, 1);
    check("R13 empty after pops", 32'(pkt_avail[1]), 0);
  endtask

  task automatic t_single_word();
    logic [31:0] v;
    wr(2, 32'hB0, 1, 1, 0);
    check("R2 not stored", 32'(pkt_avail[2]), 0);
    rreg(2'd3, 2, v); check("R2 counted", v, 1);
    rreg(2'd3, 2, v); check("R11 clear on read", v, 0);
  endtask

  task automatic t_err_drop();
    logic [31:0] v;
    wr(1, 32'hC0, 1, 0, 0);
    wr(1, 32'hC1, 0, 0, 1);
    wr(1, 32'hC2, 0, 0, 0);
    wr(1, 32'hC3, 0, 1, 0);
    check("R3 nothing visible", 32'(pkt_avail[1]), 0);
    wr(1, 32'hD0, 1, 0, 0);
    wr(1, 32'hD1, 0, 1, 0);
    pop_chk("R3 next pkt w0", 1, 32'hD0, 1, 0);
    pop_chk("R3 next pkt w1", 1, 32'hD1, 0, 1);
    rreg(2'd3, 1, v); check("R3 counted once", v, 1);
    rreg(2'd2, 0, v); check("R3 tail sets no sop error", 32'(v[1]), 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    m_full = ~(N'(1) << 3);
    for (int k = 0; k < DEPTH; k++) wr(3, 32'hE0 + k, k == 0, 0, 0);
    wr(3, 32'hEF, 0, 1, 0);
    check("R4 dropped not visible", 32'(pkt_avail[3]), 0);
    rreg(2'd3, 3, v); check("R4 counted", v, 1);
    check("R10 full irq", 32'(irq), 1);
    rreg(2'd0, 0, v); check("R8 full bit", 32'(v[3]), 1);
    rreg(2'd0, 0, v); check("R9 full cleared", 32'(v[3]), 0);
    @(negedge clk); @(negedge clk);
    check("R10 irq after clear", 32'(irq), 0);
    m_full = '1;
    wr(3, 32'hF0, 1, 0, 0);
    wr(3, 32'hF1, 0, 1, 0);
    pop_chk("R4 rollback w0", 3, 32'hF0, 1, 0);
    pop_chk("R4 rollback w1", 3, 32'hF1, 0, 1);
  endtask

  task automatic t_stream();
    logic [31:0] v;
    stream = 1;
    wr(4, 32'h40, 1, 0, 1);
    check("R5 visible at once", 32'(pkt_avail[4]), 1);
    wr(4, 32'h41, 0, 1, 0);
    wr(4, 32'h42, 1, 1, 0);
    pop_chk("R5 err word kept", 4, 32'h40, 1, 0);
    pop_chk("R5 eop word", 4, 32'h41, 0, 1);
    pop_chk("R5 single word kept", 4, 32'h42, 1, 1);
    rreg(2'd3, 4, v); check("R5 no count", v, 0);
    stream = 0;
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    port_en[5] = 0;
    wr(5, 32'h55, 1, 0, 0);
    @(negedge clk); @(negedge clk);
    check("R10 masked no irq", 32'(irq), 0);
    m_dis = ~(N'(1) << 5);
    @(negedge clk); @(negedge clk);
    check("R10 unmasked irq", 32'(irq), 1);
    check("R6 discarded", 32'(pkt_avail[5]), 0);
    rreg(2'd1, 0, v); check("R6 dis bit", v, 32'h20);
    @(negedge clk); @(negedge clk);
    check("R9 irq cleared by read", 32'(irq), 0);
    m_dis = '1; port_en[5] = 1;
  endtask

  task automatic t_soperr();
    logic [31:0] v;
    wr(6, 32'h66, 0, 1, 0);
    check("R7 discarded", 32'(pkt_avail[6]), 0);
    rreg(2'd2, 0, v); check("R7 sop err bit", v, 32'h40);
    rreg(2'd2, 0, v); check("R9 sop err cleared", v, 0);
  endtask

  task automatic t_saturate();
    logic [31:0] v;
    for (int k = 0; k < 20; k++) wr(7, 32'h7, 1, 1, 0);
    rreg(2'd3, 7, v); check("R11 saturated", v, 15);
    rreg(2'd3, 7, v); check("R11 cleared", v, 0);
    for (int k = 0; k < 3; k++) wr(7, 32'h7, 1, 1, 0);
    @(negedge clk);
    wr_en = 1; wr_port = 4'd7; wr_sop = 1; wr_eop = 1;
    reg_rd = 1; reg_sel = 2'd3; reg_port = 4'd7;
    @(negedge clk);
    wr_en = 0; wr_sop = 0; wr_eop = 0; reg_rd = 0;
    check("R12 old value", reg_rdata, 3);
    rreg(2'd3, 7, v); check("R12 left at one", v, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_saf_good();
    t_single_word();
    t_err_drop();
    t_overflow();
    t_stream();
    t_disabled();
    t_soperr();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule